// File: doc/BRIEF.md
# Banked Exception Vector Address Generator

This block keeps three exception vector base registers: one used by the secure world, one used by the non-secure world, and one used by the monitor. Software reaches them through a simple register access port. Whether an access is allowed depends on the security state and privilege of the access, and on a write-disable input that freezes the secure-side registers. A refused access raises an undefined-instruction fault and leaves all storage as it was.

The second function of the block computes the branch target when an exception is taken. The caller gives the exception type, the world it is taken in, whether high vectors are on, and three routing controls. These controls send IRQ, FIQ and external aborts to the monitor. The block adds the fixed per-type offset to the correct base. The base is the monitor base, the fixed high-vector base, the hard reset address, or the banked base of the current world. The result appears on a registered output one cycle after the request.

Top module: `vec_base_unit`

## Requirements
- R1: After reset all three bases read as 0x00000000.
- R2: Only bits [31:5] of a base are stored. Bits [4:0] always read as zero, and the values written to them are dropped.
- R3: With acc_sel=0, a privileged access reaches the secure copy when acc_secure=1 and the non-secure copy when acc_secure=0. Each copy keeps its own value.
- R4: Any access with acc_priv=0 faults and changes nothing, whatever acc_sel is.
- R5: With acc_sel=1 the monitor base is reached only by a secure privileged access. A non-secure access faults and changes nothing.
- R6: A secure privileged write to either base while wr_lock=1 faults and leaves the register unchanged. Reads are still allowed, and non-secure writes are not affected by wr_lock.
- R7: exc_type codes are 0 reset, 1 undefined, 2 SVC, 3 SMC, 4 prefetch abort, 5 data abort, 6 IRQ and 7 FIQ. Their offsets are 0x00, 0x04, 0x08, 0x08, 0x0C, 0x10, 0x18 and 0x1C. A non-monitor exception targets the base of its world (exc_secure) plus the offset.
- R8: With hivec_en=1, a non-monitor exception targets 0xFFFF0000 plus the offset, whatever the bases hold.
- R9: A reset exception targets 0x00000000 when hivec_en=0.
- R10: The monitor base plus the offset is used for every SMC. It is also used for IRQ when route_irq=1, for FIQ when route_fiq=1, and for an abort with exc_ext=1 when route_ext=1. No other exception uses it, and hivec_en has no effect on it.
- R11: vec_valid and vec_addr follow exc_valid by exactly one cycle. An exception requested in the same cycle as a base write uses the value the base held before that write.
- R12: undef_fault pulses high for one cycle, one cycle after a refused access. rd_data is updated one cycle after every access: it takes the base value on an allowed read and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 write, 0 read |
| acc_sel | input | 1 | 0 banked base, 1 monitor base |
| acc_wdata | input | 32 | Write data |
| acc_secure | input | 1 | Access made from the secure world |
| acc_priv | input | 1 | Access made in a privileged mode |
| wr_lock | input | 1 | Blocks secure writes to both bases |
| rd_data | output | 32 | Registered read data |
| undef_fault | output | 1 | Registered undefined-instruction fault |
| exc_valid | input | 1 | Exception request |
| exc_type | input | 3 | Exception type code |
| exc_secure | input | 1 | World the exception is taken in |
| exc_ext | input | 1 | Abort is external |
| hivec_en | input | 1 | High vectors enabled |
| route_irq | input | 1 | Send IRQ to the monitor |
| route_fiq | input | 1 | Send FIQ to the monitor |
| route_ext | input | 1 | Send external aborts to the monitor |
| vec_valid | output | 1 | Branch address valid |
| vec_addr | output | 32 | Branch address |

## Verification
A base write and an exception lookup can happen in the same cycle. The lookup reads the same storage the write is changing. The bench provokes this by driving a secure banked write and a secure exception on one clock edge. It expects the branch address to use the old base, and the next exception to use the new one. It also sets up locked writes, refused accesses, and every exception type under each world, high-vector and routing combination. Each result is judged against a model kept in the bench.

// File: rtl/vbu_pkg.sv
package vbu_pkg;
  typedef enum logic [2:0] {
    EX_RST  = 3'd0,
    EX_UND  = 3'd1,
    EX_SVC  = 3'd2,
    EX_SMC  = 3'd3,
    EX_PABT = 3'd4,
    EX_DABT = 3'd5,
    EX_IRQ  = 3'd6,
    EX_FIQ  = 3'd7
  } exc_e;

  localparam int NUM_BANKS = 3;
  localparam int BK_SEC  = 0;
  localparam int BK_NSEC = 1;
  localparam int BK_MON  = 2;

  function automatic logic [4:0] vec_offset(exc_e t);
    case (t)
      EX_RST:  return 5'h00;
      EX_UND:  return 5'h04;
      EX_SVC:  return 5'h08;
      EX_SMC:  return 5'h08;
      EX_PABT: return 5'h0C;
      EX_DABT: return 5'h10;
      EX_IRQ:  return 5'h18;
      default: return 5'h1C;
    endcase
  endfunction
endpackage

// File: rtl/vbu_access.sv
module vbu_access (
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_sel,
  input  logic       acc_secure,
  input  logic       acc_priv,
  input  logic       wr_lock,
  output logic [1:0] bank_idx,
  output logic       wr_en,
  output logic       rd_en,
  output logic       fault
);
  logic perm_ok;
  logic lock_hit;

  always_comb begin
    // banked register follows the world of the access; monitor is fixed
    if (acc_sel) bank_idx = 2'(vbu_pkg::BK_MON);
    else if (acc_secure) bank_idx = 2'(vbu_pkg::BK_SEC);
    else bank_idx = 2'(vbu_pkg::BK_NSEC);

    perm_ok  = acc_priv && (!acc_sel || acc_secure);
    lock_hit = acc_write && acc_secure && wr_lock;
    fault    = acc_valid && (!perm_ok || lock_hit);
    wr_en    = acc_valid && acc_write && !fault;
    rd_en    = acc_valid && !acc_write && !fault;
  end
endmodule

// File: rtl/vbu_regbank.sv
module vbu_regbank #(
  parameter int AW  = 32,
  parameter int LSB = 5,
  parameter int NB  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_idx,
  input  logic [AW-1:LSB]      wr_data,
  output logic [NB-1:0][AW-1:0] bases
);
  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [AW-1:LSB] stored;
    always_ff @(posedge clk) begin
      if (rst) stored <= '0;
      else if (wr_en && (wr_idx == 2'(g))) stored <= wr_data;
    end
    assign bases[g] = {stored, {LSB{1'b0}}};
  end
endmodule

// File: rtl/vbu_target.sv
module vbu_target #(
  parameter int          AW         = 32,
  parameter int          NB         = 3,
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NB-1:0][AW-1:0] bases,
  input  logic                  exc_valid,
  input  logic [2:0]            exc_type,
  input  logic                  exc_secure,
  input  logic                  exc_ext,
  input  logic                  hivec_en,
  input  logic                  route_irq,
  input  logic                  route_fiq,
  input  logic                  route_ext,
  output logic                  vec_valid,
  output logic [AW-1:0]         vec_addr
);
  import vbu_pkg::*;

  exc_e          kind;
  logic [AW-1:0] off;
  logic          to_mon;
  logic          is_abort;
  logic [AW-1:0] target;

  always_comb begin
    kind     = exc_e'(exc_type);
    off      = AW'(vec_offset(kind));
    is_abort = (kind == EX_PABT) || (kind == EX_DABT);
    to_mon   = (kind == EX_SMC)
            || ((kind == EX_IRQ) && route_irq)
            || ((kind == EX_FIQ) && route_fiq)
            || (is_abort && exc_ext && route_ext);
    if (to_mon) target = bases[BK_MON] + off;
    else if (hivec_en) target = AW'(HIVEC_BASE) + off;
    else if (kind == EX_RST) target = AW'(RESET_ADDR);
    else if (exc_secure) target = bases[BK_SEC] + off;
    else target = bases[BK_NSEC] + off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= exc_valid;
      if (exc_valid) vec_addr <= target;
    end
  end
endmodule

// File: rtl/vec_base_unit.sv
module vec_base_unit #(
  parameter int          AW         = 32,
  parameter int          ALIGN_LSB  = 5,
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_sel,
  input  logic [AW-1:0] acc_wdata,
  input  logic          acc_secure,
  input  logic          acc_priv,
  input  logic          wr_lock,
  output logic [AW-1:0] rd_data,
  output logic          undef_fault,
  input  logic          exc_valid,
  input  logic [2:0]    exc_type,
  input  logic          exc_secure,
  input  logic          exc_ext,
  input  logic          hivec_en,
  input  logic          route_irq,
  input  logic          route_fiq,
  input  logic          route_ext,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr
);
  localparam int NB = vbu_pkg::NUM_BANKS;

  logic [1:0]           bank_idx;
  logic                 wr_en, rd_en, fault;
  logic [NB-1:0][AW-1:0] bases;

  vbu_access u_access (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_sel   (acc_sel),
    .acc_secure(acc_secure),
    .acc_priv  (acc_priv),
    .wr_lock   (wr_lock),
    .bank_idx  (bank_idx),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .fault     (fault)
  );

  vbu_regbank #(.AW(AW), .LSB(ALIGN_LSB), .NB(NB)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (bank_idx),
    .wr_data(acc_wdata[AW-1:ALIGN_LSB]),
    .bases  (bases)
  );

  vbu_target #(.AW(AW), .NB(NB), .HIVEC_BASE(HIVEC_BASE), .RESET_ADDR(RESET_ADDR)) u_target (
    .clk       (clk),
    .rst       (rst),
    .bases     (bases),
    .exc_valid (exc_valid),
    .exc_type  (exc_type),
    .exc_secure(exc_secure),
    .exc_ext   (exc_ext),
    .hivec_en  (hivec_en),
    .route_irq (route_irq),
    .route_fiq (route_fiq),
    .route_ext (route_ext),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      undef_fault <= 1'b0;
    end else begin
      undef_fault <= fault;
      if (acc_valid) rd_data <= rd_en ? bases[bank_idx] : '0;
    end
  end
endmodule

// File: rtl/vbu_checker.sv
module vbu_checker #(
  parameter int          AW         = 32,
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic          acc_write,
  input logic          acc_sel,
  input logic          acc_secure,
  input logic          acc_priv,
  input logic          wr_lock,
  input logic [AW-1:0] rd_data,
  input logic          undef_fault,
  input logic          exc_valid,
  input logic [2:0]    exc_type,
  input logic          hivec_en,
  input logic          vec_valid,
  input logic [AW-1:0] vec_addr
);
  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[4:0] == 5'd0);

  // R4
  user_fault_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_priv |=> undef_fault);

  // R5
  mon_nsec_fault_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_sel && !acc_secure |=> undef_fault && rd_data == '0);

  // R6
  lock_write_fault_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_write && acc_secure && acc_priv && wr_lock |=> undef_fault);

  // R12
  no_spurious_fault_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !undef_fault);

  // R11
  vec_follow_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> vec_valid);

  // R11
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |=> !vec_valid);

  // R8
  hivec_und_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid && hivec_en && exc_type == 3'd1 |=> vec_addr == AW'(HIVEC_BASE) + AW'(4));
endmodule

bind vec_base_unit vbu_checker #(.AW(AW), .HIVEC_BASE(HIVEC_BASE)) i_vbu_checker (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_sel    (acc_sel),
  .acc_secure (acc_secure),
  .acc_priv   (acc_priv),
  .wr_lock    (wr_lock),
  .rd_data    (rd_data),
  .undef_fault(undef_fault),
  .exc_valid  (exc_valid),
  .exc_type   (exc_type),
  .hivec_en   (hivec_en),
  .vec_valid  (vec_valid),
  .vec_addr   (vec_addr)
);

// File: tb/test_vec_base_unit.sv
module test_vec_base_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_write = 0, acc_sel = 0, acc_secure = 0, acc_priv = 0, wr_lock = 0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic undef_fault;
  logic exc_valid = 0, exc_secure = 0, exc_ext = 0, hivec_en = 0;
  logic route_irq = 0, route_fiq = 0, route_ext = 0;
  logic [2:0] exc_type = '0;
  logic vec_valid;
  logic [31:0] vec_addr;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  vec_base_unit i_vec_base_unit (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .acc_secure(acc_secure), .acc_priv(acc_priv), .wr_lock(wr_lock),
    .rd_data(rd_data), .undef_fault(undef_fault),
    .exc_valid(exc_valid), .exc_type(exc_type), .exc_secure(exc_secure), .exc_ext(exc_ext),
    .hivec_en(hivec_en), .route_irq(route_irq), .route_fiq(route_fiq), .route_ext(route_ext),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  typedef struct packed {
    logic        sel, wr, sec, priv, lock;
    logic [31:0] data;
    logic        efault;
    logic [31:0] erd;
  } acc_vec_t;

  localparam int NV = 19;
  localparam acc_vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,1'b0,32'h0,          1'b0,32'h0},          // R1 banked
    '{1'b1,1'b0,1'b1,1'b1,1'b0,32'h0,          1'b0,32'h0},          // R1 monitor
    '{1'b0,1'b1,1'b1,1'b1,1'b0,32'h1000_001F,  1'b0,32'h0},          // R2 write
    '{1'b0,1'b0,1'b1,1'b1,1'b0,32'h0,          1'b0,32'h1000_0000},  // R2 read
    '{1'b0,1'b1,1'b0,1'b1,1'b0,32'h2000_0040,  1'b0,32'h0},          // R3
    '{1'b0,1'b0,1'b0,1'b1,1'b0,32'h0,          1'b0,32'h2000_0040},  // R3
    '{1'b0,1'b0,1'b1,1'b1,1'b0,32'h0,          1'b0,32'h1000_0000},  // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b0,32'hDEAD_0000,  1'b1,32'h0},          // R4
    '{1'b0,1'b0,1'b1,1'b1,1'b0,32'h0,          1'b0,32'h1000_0000},  // R4
    '{1'b1,1'b1,1'b0,1'b1,1'b0,32'h5555_0000,  1'b1,32'h0},          // R5
    '{1'b1,1'b0,1'b0,1'b1,1'b0,32'h0,          1'b1,32'h0},          // R5
    '{1'b1,1'b1,1'b1,1'b1,1'b0,32'h3000_00A0,  1'b0,32'h0},          // R5
    '{1'b1,1'b0,1'b1,1'b1,1'b0,32'h0,          1'b0,32'h3000_00A0},  // R5
    '{1'b0,1'b1,1'b1,1'b1,1'b1,32'h7777_0000,  1'b1,32'h0},          // R6
    '{1'b1,1'b1,1'b1,1'b1,1'b1,32'h7777_0000,  1'b1,32'h0},          // R6
    '{1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,          1'b0,32'h1000_0000},  // R6
    '{1'b0,1'b1,1'b0,1'b1,1'b1,32'h2100_0020,  1'b0,32'h0},          // R6
    '{1'b0,1'b0,1'b0,1'b1,1'b0,32'h0,          1'b0,32'h2100_0020},  // R6
    '{1'b1,1'b0,1'b1,1'b0,1'b0,32'h0,          1'b1,32'h0}           // R4
  };

  logic [31:0] m_sec = 32'h1000_0000, m_nsec = 32'h2100_0020, m_mon = 32'h3000_00A0;

  function automatic logic [31:0] model_vec(int t, logic sec, logic hiv, logic ri, logic rf,
                                            logic re, logic ext,
                                            logic [31:0] s, logic [31:0] n, logic [31:0] m);
    logic [31:0] off;
    logic mon;
    case (t)
      0: off = 32'h00; 1: off = 32'h04; 2: off = 32'h08; 3: off = 32'h08;
      4: off = 32'h0C; 5: off = 32'h10; 6: off = 32'h18; default: off = 32'h1C;
    endcase
    mon = (t == 3) || (t == 6 && ri) || (t == 7 && rf) || ((t == 4 || t == 5) && ext && re);
    if (mon) return m + off;
    if (hiv) return 32'hFFFF_0000 + off;
    if (t == 0) return 32'h0;
    return (sec ? s : n) + off;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_exc(int t, logic sec, logic hiv, logic ri, logic rf, logic re, logic ext);
    @(negedge clk);
    exc_valid = 1; exc_type = 3'(t); exc_secure = sec; hivec_en = hiv;
    route_irq = ri; route_fiq = rf; route_ext = re; exc_ext = ext;
    @(negedge clk);
    exc_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 32'h0);
    check("R11 reset vec_valid", {31'b0, vec_valid}, 32'h0);
    check("R12 reset fault", {31'b0, undef_fault}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_valid = 1; acc_sel = TBL[i].sel; acc_write = TBL[i].wr; acc_secure = TBL[i].sec;
      acc_priv = TBL[i].priv; wr_lock = TBL[i].lock; acc_wdata = TBL[i].data;
      @(negedge clk);
      acc_valid = 0; wr_lock = 0;
      check($sformatf("R12 fault vec %0d", i), {31'b0, undef_fault}, {31'b0, TBL[i].efault});
      check($sformatf("R3 rd_data vec %0d", i), rd_data, TBL[i].erd);
      @(negedge clk);
      check("R12 fault one pulse", {31'b0, undef_fault}, 32'h0);
    end

    for (int s = 0; s < 2; s++)
      for (int h = 0; h < 2; h++)
        for (int r = 0; r < 2; r++)
          for (int t = 0; t < 8; t++) begin
            do_exc(t, s[0], h[0], r[0], r[0], r[0], r[0]);
            check($sformatf("R7 R8 R9 R10 vec t=%0d s=%0d h=%0d r=%0d", t, s, h, r), vec_addr,
                  model_vec(t, s[0], h[0], r[0], r[0], r[0], r[0], m_sec, m_nsec, m_mon));
            check("R11 vec_valid", {31'b0, vec_valid}, 32'h1);
          end

    // R10: routing set but abort not external stays on the world base
    do_exc(5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R10 non-external abort", vec_addr, 32'h1000_0010);
    // R10: SMC ignores high vectors
    do_exc(3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 SMC with hivec", vec_addr, 32'h3000_00A8);
    @(negedge clk);
    check("R11 vec_valid drops", {31'b0, vec_valid}, 32'h0);

    // R11: write and exception in the same cycle
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_sel = 0; acc_secure = 1; acc_priv = 1;
    acc_wdata = 32'h4000_0000;
    exc_valid = 1; exc_type = 3'd1; exc_secure = 1; hivec_en = 0;
    route_irq = 0; route_fiq = 0; route_ext = 0; exc_ext = 0;
    @(negedge clk);
    acc_valid = 0; exc_valid = 0;
    check("R11 same-cycle uses old base", vec_addr, 32'h1000_0004);
    do_exc(1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 next exception uses new base", vec_addr, 32'h4000_0004);

    // R1: reset clears bases again
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    do_exc(6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 base cleared by reset", vec_addr, 32'h0000_0018);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule